// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for a word load or store that uses a register-indirect mode. A base register value is combined with a second operand. That operand is either an immediate offset or the value of an index register, chosen per request. The unit also produces the new value for the base register when the access updates that register (autoindexing), together with an enable that tells the register file whether to write it.

Two timings are supported. In pre-index, the sum is used as the address and can also be written back if the request asks for it. In post-index, the unmodified base is used as the address and the sum is always written back. All arithmetic is modulo 2^32, and the index operand is read as a two's-complement value.

A word address that is not a multiple of four raises an informational flag. The unit also maps a register word onto four little-endian memory byte lanes for stores, and assembles four lanes into a word for loads. Each request is accepted on a clock edge, and its results appear at the outputs one cycle later.

Top module: `lsu_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared to zero on that edge.
- R2: A request sampled with `req_vld` high produces `rsp_vld` high on the next cycle, with that request's results on every other output.
- R3: Pre-index (`post_mode`=0) without write-back (`wb_req`=0): `eff_addr` = base + operand, `base_we` = 0, and `base_next` equals the unchanged base.
- R4: Pre-index with write-back (`post_mode`=0, `wb_req`=1): `eff_addr` = base + operand, `base_next` is that same sum, and `base_we` = 1.
- R5: Post-index (`post_mode`=1): `eff_addr` = base, `base_next` = base + operand, and `base_we` = 1 whatever the value of `wb_req`.
- R6: `sel_reg`=1 selects `idx_val` as the operand and `sel_reg`=0 selects `imm_val`. The index is two's-complement, so base 0x108 with index 0xFFFFFFF8 gives 0x100.
- R7: Sums wrap modulo 2^32 and carry no overflow indication. For example, 0xFFFFFFFC + 8 gives 0x00000004.
- R8: `misalign` is 1 exactly when bits [1:0] of `eff_addr` are not both zero. `eff_addr`, `base_next` and `base_we` are still produced as in R3 to R5.
- R9: Store lanes are little-endian: `st_lanes[7:0]` is the byte for address `eff_addr`+0 and `st_lanes[31:24]` the byte for `eff_addr`+3. A word of 0x12345678 puts 0x78 in lane 0 and 0x12 in lane 3.
- R10: Load assembly is little-endian: `ld_lanes[7:0]` (address +0) becomes `ld_word[7:0]` and `ld_lanes[31:24]` (address +3) becomes `ld_word[31:24]`.
- R11: A cycle with `req_vld` low gives `rsp_vld`, `base_we` and `misalign` all 0 on the next cycle, and `eff_addr`, `base_next`, `st_lanes` and `ld_word` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Request present this cycle |
| base_val | input | 32 | Current base register value |
| imm_val | input | 32 | Immediate offset |
| idx_val | input | 32 | Index register value, two's-complement |
| sel_reg | input | 1 | 1 selects index register, 0 selects immediate |
| post_mode | input | 1 | 1 post-index, 0 pre-index |
| wb_req | input | 1 | Write-back requested (pre-index only) |
| st_word | input | 32 | Register word to be stored |
| ld_lanes | input | 32 | Memory bytes read, lane k at bits 8k+7:8k |
| rsp_vld | output | 1 | Results valid for the previous request |
| eff_addr | output | 32 | Effective address |
| base_next | output | 32 | Value for the base register |
| base_we | output | 1 | Base register write enable |
| misalign | output | 1 | Word address not a multiple of four |
| st_lanes | output | 32 | Store bytes, lane k for address eff_addr+k |
| ld_word | output | 32 | Assembled load word |

## Verification
The unit keeps no state across requests beyond its output register. A corrupted output register, such as a stale sum, the wrong timing mux or a write enable left set, therefore shows at the ports on the very next cycle. It also clears itself with the following request.

A behavioural model in the bench predicts every output on every clock. A wrong choice between base and sum, a missing sign extension or a swapped byte lane is caught on the first request that exercises it. The stimulus therefore walks through each mode, negative indices, wrap-around, odd addresses and idle gaps.

// File: rtl/agu_pkg.sv
// Package: shared types for the load/store address generator.
// Assumes callers cast raw control bits to these enums.
package agu_pkg;
    typedef enum logic {
        OPND_IMM = 1'b0,
        OPND_REG = 1'b1
    } opnd_src_e;

    typedef enum logic {
        UPD_BEFORE = 1'b0,
        UPD_AFTER  = 1'b1
    } upd_time_e;
endpackage

// File: rtl/agu_offset_sel.sv
// Module: agu_offset_sel
// Picks the second address operand: the immediate or the index register.
// Assumes both values arrive already W bits wide in two's complement, so no
// extension is needed here.
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int W = 32
) (
    input  opnd_src_e      src,
    input  logic [W-1:0]   imm_val,
    input  logic [W-1:0]   idx_val,
    output logic [W-1:0]   opnd
);
    // Operand multiplexer.
    always_comb begin
        if (src == OPND_REG) opnd = idx_val;
        else                 opnd = imm_val;
    end
endmodule

// File: rtl/agu_addr_calc.sv
// Module: agu_addr_calc
// Forms the effective address, the base write-back value and its enable,
// and the misalignment flag. Purely combinational.
// Assumes wrap-around arithmetic modulo 2^W. When no write-back occurs, the
// write-back value carries the unchanged base.
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int W     = 32,
    parameter int LANES = 4
) (
    input  logic [W-1:0]   base,
    input  logic [W-1:0]   opnd,
    input  upd_time_e      timing,
    input  logic           wb_req,
    output logic [W-1:0]   ea,
    output logic [W-1:0]   nb,
    output logic           we,
    output logic           mis
);
    localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [W-1:0] sum;

    // Modulo adder shared by both timings.
    always_comb sum = base + opnd;

    // Timing mux: address, write-back enable and write-back value.
    always_comb begin
        if (timing == UPD_AFTER) begin
            ea = base;
            we = 1'b1;
        end else begin
            ea = sum;
            we = wb_req;
        end
        nb = we ? sum : base;
    end

    // Word alignment test on the low address bits.
    always_comb mis = (ea[LSB_W-1:0] != '0);
endmodule

// File: rtl/agu_lane_pack.sv
// Module: agu_lane_pack
// Maps a register word onto little-endian memory byte lanes, and back.
// Lane k holds the byte at address offset k.
// Assumes DW is a multiple of 8.
module agu_lane_pack #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]  st_word,
    input  logic [DW-1:0]  ld_lanes,
    output logic [DW-1:0]  st_lanes,
    output logic [DW-1:0]  ld_word
);
    localparam int NB = DW / 8;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        // Lane k carries word bits [8k+7:8k] in both directions.
        always_comb begin
            st_lanes[k*8 +: 8] = st_word[k*8 +: 8];
            ld_word[k*8 +: 8]  = ld_lanes[k*8 +: 8];
        end
    end
endmodule

// File: rtl/lsu_addr_gen.sv
// Module: lsu_addr_gen (top)
// Address generation for word loads and stores in register-indirect modes,
// with pre- and post-index autoindexing and little-endian lane packing.
// All results are registered, so a request is answered one cycle later.
// Assumes a synchronous active-low reset. The misalignment flag is
// informational only and suppresses nothing.
module lsu_addr_gen
    import agu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_vld,
    input  logic [AW-1:0]  base_val,
    input  logic [AW-1:0]  imm_val,
    input  logic [AW-1:0]  idx_val,
    input  logic           sel_reg,
    input  logic           post_mode,
    input  logic           wb_req,
    input  logic [DW-1:0]  st_word,
    input  logic [DW-1:0]  ld_lanes,
    output logic           rsp_vld,
    output logic [AW-1:0]  eff_addr,
    output logic [AW-1:0]  base_next,
    output logic           base_we,
    output logic           misalign,
    output logic [DW-1:0]  st_lanes,
    output logic [DW-1:0]  ld_word
);
    localparam int LANES = DW / 8;
    localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [AW-1:0] opnd;
    logic [AW-1:0] c_ea;
    logic [AW-1:0] c_nb;
    logic          c_we;
    logic          c_mis;
    logic [DW-1:0] c_st;
    logic [DW-1:0] c_ld;

    agu_offset_sel #(.W(AW)) u_sel (
        .src     (opnd_src_e'(sel_reg)),
        .imm_val (imm_val),
        .idx_val (idx_val),
        .opnd    (opnd)
    );

    agu_addr_calc #(.W(AW), .LANES(LANES)) u_calc (
        .base    (base_val),
        .opnd    (opnd),
        .timing  (upd_time_e'(post_mode)),
        .wb_req  (wb_req),
        .ea      (c_ea),
        .nb      (c_nb),
        .we      (c_we),
        .mis     (c_mis)
    );

    agu_lane_pack #(.DW(DW)) u_pack (
        .st_word  (st_word),
        .ld_lanes (ld_lanes),
        .st_lanes (c_st),
        .ld_word  (c_ld)
    );

    // Strobes: valid, write enable and flag, live for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            base_we  <= 1'b0;
            misalign <= 1'b0;
        end else begin
            rsp_vld  <= req_vld;
            base_we  <= req_vld & c_we;
            misalign <= req_vld & c_mis;
        end
    end

    // Data results: loaded on a request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr  <= '0;
            base_next <= '0;
            st_lanes  <= '0;
            ld_word   <= '0;
        end else if (req_vld) begin
            eff_addr  <= c_ea;
            base_next <= c_nb;
            st_lanes  <= c_st;
            ld_word   <= c_ld;
        end
    end

    // Assertions guarding the output register against the request inputs.
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !base_we && !misalign && $stable(eff_addr)
                      && $stable(base_next)));

    p_base_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !post_mode && !wb_req) |=>
            (!base_we && base_next == $past(base_val)));

    p_pre_wb_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !post_mode && wb_req) |=> (base_we && base_next == eff_addr));

    p_post_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && post_mode) |=> (base_we && eff_addr == $past(base_val)));

    p_misalign_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (misalign == (eff_addr[LSB_W-1:0] != '0)));
endmodule

// File: tb/lsu_addr_gen_test.sv
// Bench for lsu_addr_gen. A behavioural model, updated at each rising edge,
// predicts every output, and the outputs are compared at every falling edge.
module lsu_addr_gen_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [31:0] base_val = '0, imm_val = '0, idx_val = '0;
    logic        sel_reg = 1'b0, post_mode = 1'b0, wb_req = 1'b0;
    logic [31:0] st_word = '0, ld_lanes = '0;
    logic        rsp_vld, base_we, misalign;
    logic [31:0] eff_addr, base_next, st_lanes, ld_word;

    int   n_checks = 0;
    int   n_fails = 0;
    int   cyc = 0;
    bit   done = 0;
    bit   compare_on = 0;
    string tag = "R1";

    // expected state
    logic        e_vld = 0, e_we = 0, e_mis = 0;
    logic [31:0] e_ea = 0, e_nb = 0, e_st = 0, e_ld = 0;

    lsu_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .base_val(base_val),
        .imm_val(imm_val), .idx_val(idx_val), .sel_reg(sel_reg),
        .post_mode(post_mode), .wb_req(wb_req), .st_word(st_word),
        .ld_lanes(ld_lanes), .rsp_vld(rsp_vld), .eff_addr(eff_addr),
        .base_next(base_next), .base_we(base_we), .misalign(misalign),
        .st_lanes(st_lanes), .ld_word(ld_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: follows the requirement text directly.
    always @(posedge clk) begin
        longint sum;
        longint opnd;
        if (!rst_n) begin
            e_vld = 0; e_we = 0; e_mis = 0;
            e_ea = 0; e_nb = 0; e_st = 0; e_ld = 0;
        end else if (req_vld) begin
            opnd = sel_reg ? longint'(idx_val) : longint'(imm_val);
            sum  = (longint'(base_val) + opnd) % 64'h1_0000_0000;
            e_vld = 1;
            e_ea  = post_mode ? base_val : 32'(sum);
            e_we  = post_mode ? 1'b1 : wb_req;
            e_nb  = e_we ? 32'(sum) : base_val;
            e_mis = (e_ea % 4) != 0;
            for (int k = 0; k < 4; k++) begin
                e_st[k*8 +: 8] = st_word[k*8 +: 8];
                e_ld[k*8 +: 8] = ld_lanes[k*8 +: 8];
            end
        end else begin
            e_vld = 0; e_we = 0; e_mis = 0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the rising edge.
    always @(negedge clk) begin
        if (compare_on) begin
            chk(e_vld ? "R2" : "R11", "rsp_vld", 32'(rsp_vld), 32'(e_vld));
            chk(tag, "eff_addr", eff_addr, e_ea);
            chk(tag, "base_next", base_next, e_nb);
            chk(tag, "base_we", 32'(base_we), 32'(e_we));
            chk("R8", "misalign", 32'(misalign), 32'(e_mis));
            chk("R9", "st_lanes", st_lanes, e_st);
            chk("R10", "ld_word", ld_word, e_ld);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic issue(input string t, input logic [31:0] b, input logic [31:0] imm,
                         input logic [31:0] idx, input logic s, input logic p,
                         input logic w, input logic [31:0] sw, input logic [31:0] ll);
        @(negedge clk);
        req_vld = 1; base_val = b; imm_val = imm; idx_val = idx;
        sel_reg = s; post_mode = p; wb_req = w; st_word = sw; ld_lanes = ll;
        @(posedge clk);
        tag = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_vld = 0; base_val = 32'hDEAD_BEE0 + i; imm_val = 32'h40;
            @(posedge clk);
            tag = "R11";
        end
    endtask

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1357_9BDF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared under reset
        chk("R1", "rsp_vld", 32'(rsp_vld), 0);
        chk("R1", "eff_addr", eff_addr, 0);
        chk("R1", "base_next", base_next, 0);
        chk("R1", "base_we", 32'(base_we), 0);
        chk("R1", "misalign", 32'(misalign), 0);
        rst_n = 1;
        compare_on = 1;
        // R3 pre-index, no write-back, immediate and index
        issue("R3", 32'h100, 32'h4, 32'h0, 0, 0, 0, 32'h0, 32'h0);
        issue("R3", 32'h100, 32'h99, 32'h4, 1, 0, 0, 32'h0, 32'h0);
        idle(2);
        // R4 pre-index with write-back
        issue("R4", 32'h100, 32'h4, 32'h0, 0, 0, 1, 32'h0, 32'h0);
        // R6 negative index: 0x108 + 0xFFFFFFF8 = 0x100
        issue("R6", 32'h108, 32'h4, 32'hFFFF_FFF8, 1, 0, 1, 32'h0, 32'h0);
        // R5 post-index ignores wb_req=0
        issue("R5", 32'h200, 32'h4, 32'h0, 0, 1, 0, 32'h0, 32'h0);
        issue("R5", 32'h300, 32'h0, 32'hFFFF_FFFC, 1, 1, 1, 32'h0, 32'h0);
        // R7 wrap-around
        issue("R7", 32'hFFFF_FFFC, 32'h8, 32'h0, 0, 0, 1, 32'h0, 32'h0);
        issue("R7", 32'h4, 32'h0, 32'hFFFF_FFF0, 1, 1, 0, 32'h0, 32'h0);
        // R8 misaligned, outputs still produced
        issue("R8", 32'h102, 32'h0, 32'h0, 0, 0, 1, 32'h0, 32'h0);
        issue("R8", 32'h101, 32'h3, 32'h0, 0, 1, 0, 32'h0, 32'h0);
        issue("R8", 32'h100, 32'h1, 32'h0, 0, 0, 0, 32'h0, 32'h0);
        // R9 / R10 lanes: 0x12345678 -> lane0 0x78, lane3 0x12
        issue("R9", 32'h100, 32'h0, 32'h0, 0, 0, 0, 32'h1234_5678, 32'hAABB_CCDD);
        @(negedge clk);
        chk("R9", "lane0", 32'(st_lanes[7:0]), 32'h78);
        chk("R9", "lane3", 32'(st_lanes[31:24]), 32'h12);
        chk("R10", "ld_word", ld_word, 32'hAABB_CCDD);
        idle(3);
        // mixed patterns
        for (int i = 0; i < 200; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            issue(lcg[2] ? "R5" : (lcg[3] ? "R4" : "R3"), lcg ^ 32'h5A5A_0000,
                  {lcg[15:0], lcg[31:16]}, ~lcg, lcg[1], lcg[2], lcg[3],
                  lcg * 3, lcg + 7);
            if (lcg[9:8] == 0) idle(1);
        end
        idle(2);
        done = 1;
        compare_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule